// File: doc/BRIEF.md
# Parity-Framed ID Serialiser

This block turns a 40-bit identifier into the 64-bit framed bitstream of a common read-only 125 kHz proximity ID format. The frame opens with a run of nine 1s. The identifier follows in ten rows of four bits, and each row carries its own even parity bit. Four column parity bits and a single 0 stop bit close the frame.

The frame is available in two forms at the same time. A serial output moves forward one frame bit on each bit-strobe and repeats the frame without end. A frame-start flag marks the first header bit. The same frame is also presented as two 32-bit words, the first half and the second half, ready to be programmed into two data blocks of a writable transponder. A fixed configuration word for that transponder comes with them.

The serial path works out parity as bits leave, while the parallel words are built combinationally. A new identifier can be offered with a load strobe at any time, but it only takes effect when the current frame wraps. The serial stream never carries a mix of two identifiers.

Top module: `idframe_ser`

## Requirements
- R1: After reset the serial position is the first header bit, `frame_start` is 1 and the active identifier is zero, so `word_hi` = 0xFF800000 and `word_lo` = 0x00000000.
- R2: Serial frame bits 0 to 8 are all 1. `frame_start` is 1 exactly while bit 0 is presented.
- R3: Serial bits 9 to 58 carry the identifier MSB first in ten rows of four bits. Each row is followed by a bit that makes that row's five bits even in parity.
- R4: Serial bits 59 to 62 are column parities: bit 59+c is the XOR of bit c (counted from the first bit of each row) over all ten rows. Serial bit 63 is 0.
- R5: `word_hi` equals serial frame bits 0 to 31, with bit 0 in its MSB. `word_lo` equals bits 32 to 63, with bit 32 in its MSB.
- R6: `cfg_word` is always 0x00148040 (bit rate RF/64, Manchester coding, two data blocks).
- R7: Each cycle with `bit_stb` high moves the serial position forward by one, and after bit 63 it returns to bit 0. Without `bit_stb`, `ser_bit` and `frame_start` hold.
- R8: `load` captures `id_in`, and the captured value becomes the active identifier on the strobe that leaves bit 63. If several loads come within one frame, the latest one wins. A load in the same cycle as that wrap strobe takes effect at once. Until then the words and the serial stream keep the old identifier.
- R9: The 64 serial bits sent from one `frame_start` onward equal {`word_hi`, `word_lo`} as presented at that frame start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load | input | 1 | Capture `id_in` for the next frame |
| id_in | input | 40 | Identifier to frame |
| bit_stb | input | 1 | Advance the serial output by one bit |
| ser_bit | output | 1 | Current frame bit |
| frame_start | output | 1 | High while the first header bit is presented |
| word_hi | output | 32 | First 32 frame bits |
| word_lo | output | 32 | Last 32 frame bits |
| cfg_word | output | 32 | Transponder configuration word |

## Verification
The assertions assume nothing about how often `bit_stb` or `load` arrive. They do assume that reset is held for at least one clock before any check is trusted, and that the identifier only changes through `load` at a wrap. The stimulus covers these conditions: dense and sparse strobe patterns, loads placed mid-frame, several loads in one frame, and a load that lands exactly on the wrap strobe. Both all-zero and all-one identifiers are used, so every parity path sees both values.

// File: rtl/idframe_ser.sv
module idframe_ser #(
  parameter int          ID_W    = 40,
  parameter int          ROW_W   = 4,
  parameter int          HDR_LEN = 9,
  parameter logic [31:0] CFG     = 32'h00148040
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [ID_W-1:0] id_in,
  input  logic            bit_stb,
  output logic            ser_bit,
  output logic            frame_start,
  output logic [31:0]     word_hi,
  output logic [31:0]     word_lo,
  output logic [31:0]     cfg_word
);
  localparam int ROWS     = ID_W / ROW_W;
  localparam int BODY_END = HDR_LEN + ROWS * (ROW_W + 1);
  localparam int COL_END  = BODY_END + ROW_W;
  localparam int FRAME    = COL_END + 1;
  localparam int HALF     = FRAME / 2;
  localparam int PW       = $clog2(FRAME);
  localparam int SW       = $clog2(ROW_W + 1);
  localparam int CW       = $clog2(ROW_W);

  logic [PW-1:0]    pos;
  logic [SW-1:0]    sub;
  logic [ID_W-1:0]  shreg, id_q, stage, nxt_id;
  logic [ROW_W-1:0] cpar;
  logic             rpar, pend;
  logic             in_hdr, in_body, in_col, is_par, last;
  logic [FRAME-1:0] frame_vec;

  function automatic logic [FRAME-1:0] build(input logic [ID_W-1:0] v);
    logic [FRAME-1:0] f;
    logic [ROW_W-1:0] cp;
    logic             rp;
    f  = '0;
    cp = '0;
    for (int h = 0; h < HDR_LEN; h++) f[FRAME-1-h] = 1'b1;
    for (int r = 0; r < ROWS; r++) begin
      rp = 1'b0;
      for (int c = 0; c < ROW_W; c++) begin
        f[FRAME-1-HDR_LEN-r*(ROW_W+1)-c] = v[ID_W-1-r*ROW_W-c];
        rp    = rp ^ v[ID_W-1-r*ROW_W-c];
        cp[c] = cp[c] ^ v[ID_W-1-r*ROW_W-c];
      end
      f[FRAME-1-HDR_LEN-r*(ROW_W+1)-ROW_W] = rp;
    end
    for (int c = 0; c < ROW_W; c++) f[FRAME-1-BODY_END-c] = cp[c];
    return f;
  endfunction

  assign frame_vec   = build(id_q);
  assign word_hi     = frame_vec[FRAME-1 -: HALF];
  assign word_lo     = frame_vec[HALF-1:0];
  assign cfg_word    = CFG;

  assign in_hdr      = pos < PW'(HDR_LEN);
  assign in_body     = pos < PW'(BODY_END);
  assign in_col      = pos < PW'(COL_END);
  assign is_par      = sub == SW'(ROW_W);
  assign last        = pos == PW'(FRAME - 1);
  assign frame_start = pos == '0;
  assign nxt_id      = load ? id_in : (pend ? stage : id_q);

  always_comb begin
    if (in_hdr)       ser_bit = 1'b1;
    else if (in_body) ser_bit = is_par ? rpar : shreg[ID_W-1];
    else if (in_col)  ser_bit = cpar[sub[CW-1:0]];
    else              ser_bit = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos   <= '0;
      sub   <= '0;
      shreg <= '0;
      id_q  <= '0;
      stage <= '0;
      pend  <= 1'b0;
      rpar  <= 1'b0;
      cpar  <= '0;
    end else begin
      if (load) begin
        stage <= id_in;
        pend  <= 1'b1;
      end
      if (bit_stb) begin
        if (last) begin
          pos   <= '0;
          sub   <= '0;
          rpar  <= 1'b0;
          cpar  <= '0;
          shreg <= nxt_id;
          id_q  <= nxt_id;
          pend  <= 1'b0;
        end else begin
          pos <= pos + 1'b1;
          if (!in_hdr && in_body) begin
            if (is_par) begin
              rpar <= 1'b0;
              sub  <= '0;
            end else begin
              shreg              <= shreg << 1;
              rpar               <= rpar ^ shreg[ID_W-1];
              cpar[sub[CW-1:0]]  <= cpar[sub[CW-1:0]] ^ shreg[ID_W-1];
              sub                <= sub + 1'b1;
            end
          end else if (!in_body && in_col) begin
            sub <= sub + 1'b1;
          end
        end
      end
    end
  end

  AST_SER_EQ_WORDS: assert property (@(posedge clk) disable iff (!rst_n)
    ser_bit == frame_vec[PW'(FRAME - 1) - pos]); // R9
  AST_START_IS_HEADER: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> ser_bit); // R2
  AST_STOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    last |-> !ser_bit); // R4
  AST_HOLD_NO_STB: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_stb |=> $stable(ser_bit) && $stable(frame_start)); // R7
  AST_WRAP_TO_START: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_stb && last) |=> frame_start); // R7
  AST_ID_HELD_MIDFRAME: assert property (@(posedge clk) disable iff (!rst_n)
    !(bit_stb && last) |=> $stable(word_hi) && $stable(word_lo)); // R8
endmodule

// File: tb/idframe_ser_bench.sv
module idframe_ser_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load = 1'b0;
  logic [39:0] id_in = '0;
  logic        bit_stb = 1'b0;
  logic        ser_bit, frame_start;
  logic [31:0] word_hi, word_lo, cfg_word;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  int          m_pos = 0;
  logic [39:0] m_id = '0, m_stage = '0;
  bit          m_pend = 1'b0;
  bit          prev_stb = 1'b1;
  bit          first = 1'b1;
  bit          collecting = 1'b0;
  logic        got[$];
  logic [63:0] cap_words;

  always #2 clk = ~clk;

  idframe_ser u_idframe_ser (
    .clk(clk), .rst_n(rst_n), .load(load), .id_in(id_in), .bit_stb(bit_stb),
    .ser_bit(ser_bit), .frame_start(frame_start), .word_hi(word_hi),
    .word_lo(word_lo), .cfg_word(cfg_word)
  );

  function automatic logic [63:0] ref_frame(input logic [39:0] v);
    logic q[$];
    logic [63:0] out;
    int colx [4];
    for (int i = 0; i < 4; i++) colx[i] = 0;
    for (int i = 0; i < 9; i++) q.push_back(1'b1);
    for (int r = 0; r < 10; r++) begin
      int ones = 0;
      for (int c = 0; c < 4; c++) begin
        logic b = v[39 - (r * 4 + c)];
        q.push_back(b);
        ones += int'(b);
        colx[c] += int'(b);
      end
      q.push_back(logic'(ones % 2));
    end
    for (int c = 0; c < 4; c++) q.push_back(logic'(colx[c] % 2));
    q.push_back(1'b0);
    for (int i = 0; i < 64; i++) out[63 - i] = q[i];
    return out;
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s pos=%0d actual=%h expected=%h", tag, m_pos, act, exp);
    end
  endtask

  task automatic compare_all;
    logic [63:0] f;
    string ts, tw;
    f = ref_frame(m_id);
    if (first) ts = "R1";
    else if (!prev_stb) ts = "R7";
    else if (m_pos < 9) ts = "R2";
    else if (m_pos < 59) ts = "R3";
    else ts = "R4";
    tw = first ? "R1" : (m_pend ? "R8" : "R5");
    check(ts, 64'(ser_bit), 64'(f[63 - m_pos]));
    check(first ? "R1" : "R2", 64'(frame_start), 64'(m_pos == 0));
    check(tw, 64'(word_hi), 64'(f[63:32]));
    check(tw, 64'(word_lo), 64'(f[31:0]));
    check("R6", 64'(cfg_word), 64'h00148040);
    first = 1'b0;
  endtask

  task automatic step(input bit stb, input bit ld, input logic [39:0] v);
    compare_all();
    if (stb) begin
      if (m_pos == 0) begin
        collecting = 1'b1;
        got.delete();
        cap_words = {word_hi, word_lo};
      end
      if (collecting) begin
        got.push_back(ser_bit);
        if (got.size() == 64) begin
          logic [63:0] s;
          for (int i = 0; i < 64; i++) s[63 - i] = got[i];
          check("R9", s, cap_words);
          collecting = 1'b0;
        end
      end
    end
    bit_stb = stb;
    load    = ld;
    id_in   = v;
    if (ld) begin
      m_stage = v;
      m_pend  = 1'b1;
    end
    if (stb) begin
      if (m_pos == 63) begin
        m_id   = ld ? v : (m_pend ? m_stage : m_id);
        m_pend = 1'b0;
        m_pos  = 0;
      end else m_pos++;
    end
    prev_stb = stb;
    @(negedge clk);
  endtask

  task automatic run(input int cycles, input int stb_pct);
    for (int i = 0; i < cycles; i++)
      step(($urandom % 100) < stb_pct, 1'b0, '0);
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    run(200, 100);
    step(1'b1, 1'b1, 40'h123456789A);
    run(300, 100);
    run(600, 30);
    step(1'b0, 1'b1, 40'hFFFFFFFFFF);
    run(20, 50);
    step(1'b1, 1'b1, 40'hA5A5A5A5A5);
    run(20, 50);
    step(1'b0, 1'b1, 40'h0F1E2D3C4B);
    run(400, 60);
    while (m_pos != 63) step(1'b1, 1'b0, '0);
    step(1'b1, 1'b1, 40'hFFFFFFFFFF);
    run(300, 100);
    while (m_pos != 63) step(1'b1, 1'b0, '0);
    step(1'b1, 1'b1, 40'h0000000001);
    run(200, 100);
    for (int k = 0; k < 12; k++) begin
      step(1'b1, 1'b1, {$urandom, 8'($urandom)});
      run(150, 20 + 7 * k);
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule